// File: doc/BRIEF.md
# Protected Memory Control and Single-Error Count Register

This block is one control-and-status word on a peripheral bus, placed beside a memory that carries error-correcting checkbits. Software uses it to switch correction on and to turn on two diagnostic bypass paths. One bypass records the stored checkbits of each word the memory reads. The other stores a checkbit value chosen by software in place of the computed one. The block also counts the single-bit errors that the memory controller corrects.

The memory controller sends the block a one-cycle pulse for each corrected single error. On each completed memory read it sends a strobe together with the checkbits of that word. The block drives the correction enable, the two bypass flags and the held test checkbits back to the controller. A register access takes one cycle. A write strobe updates the whole word at the next clock edge. The read data is always the current register contents.

The checkbit width, the counter width and the bus width are parameters. With the defaults (bus 32, checkbits 7, counter 8) the word is laid out as follows. The count sits in bits [7:0] and the test checkbits in bits [14:8]. Write bypass is bit 29, read bypass is bit 30 and correction enable is bit 31. All other bits read as zero.

Top module: `edac_cfg_reg`

## Requirements
- R1: While the synchronous reset `rst` is high, at every clock edge all fields return to zero, and so do all outputs.
- R2: A one-cycle pulse on `err_single` raises the count in bits [7:0] by one at the next edge. This applies when the count is below 255 and the same cycle carries no clearing write.
- R3: The count holds at 255 and never wraps to zero when further error pulses arrive.
- R4: A register write whose bits [7:0] equal 255 sets the count to zero at the next edge.
- R5: A register write whose bits [7:0] are any value other than 255 leaves the count unchanged.
- R6: When read bypass (bit 30) is set and `rd_done` is high, the test-checkbit field (bits [14:8]) and `tst_chk` take the value of `rd_chk` at the next edge.
- R7: When a register write and a read-bypass capture fall in the same cycle, the test-checkbit field takes the written bits [14:8].
- R8: When an error pulse and a clearing write (bits [7:0] equal 255) fall in the same cycle, the count becomes zero.
- R9: A register write loads bits 31, 30 and 29 into `edac_en`, `rd_byp` and `wr_byp` at the next edge. The read data shows them at the same bit positions.
- R10: While read bypass is clear, `rd_done` has no effect on the test-checkbit field, and `tst_chk` holds its value when no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Current register contents |
| err_single | input | 1 | Pulse per corrected single-bit error |
| rd_done | input | 1 | Memory read completed |
| rd_chk | input | CBW | Stored checkbits of the word just read |
| edac_en | output | 1 | Correction enable to the memory controller |
| rd_byp | output | 1 | Read-bypass flag |
| wr_byp | output | 1 | Write-bypass flag |
| tst_chk | output | CBW | Checkbits to store while write bypass is set |

## Verification
The bench builds the block with its default widths: a 32-bit bus, 7 checkbits and an 8-bit counter. The narrow counter lets a run of a few hundred error pulses reach saturation, so the bench can check the hold at 255 and the clear-versus-increment collision at the top of the range. The 7-bit checkbit field is small enough that captured and written values can be told apart in every collision case.

// File: rtl/edac_cfg_pkg.sv
package edac_cfg_pkg;
  typedef struct packed {
    logic en;
    logic rb;
    logic wb;
  } ctl_t;
endpackage

// File: rtl/edac_cfg_ctl.sv
module edac_cfg_ctl
  import edac_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  ctl_t wr_ctl,
  output ctl_t ctl
);
  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else if (wr) ctl <= wr_ctl;
  end
endmodule

// File: rtl/edac_cfg_tcb.sv
module edac_cfg_tcb #(
  parameter int CBW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [CBW-1:0] wr_val,
  input  logic           cap_en,
  input  logic           rd_done,
  input  logic [CBW-1:0] rd_chk,
  output logic [CBW-1:0] tcb
);
  always_ff @(posedge clk) begin
    if (rst) tcb <= '0;
    else if (wr) tcb <= wr_val;
    else if (cap_en && rd_done) tcb <= rd_chk;
  end
endmodule

// File: rtl/edac_cfg_cnt.sv
module edac_cfg_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic clr;
  assign clr = wr && (wr_val == TOP);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/edac_cfg_reg.sv
module edac_cfg_reg
  import edac_cfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CBW    = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              err_single,
  input  logic              rd_done,
  input  logic [CBW-1:0]    rd_chk,
  output logic              edac_en,
  output logic              rd_byp,
  output logic              wr_byp,
  output logic [CBW-1:0]    tst_chk
);
  localparam int TCB_LO = CNT_W;
  localparam int TCB_HI = CNT_W + CBW - 1;
  localparam int EN_BIT = DATA_W - 1;
  localparam int RB_BIT = DATA_W - 2;
  localparam int WB_BIT = DATA_W - 3;

  ctl_t             ctl, wr_ctl;
  logic [CNT_W-1:0] sec;

  assign wr_ctl.en = reg_wdata[EN_BIT];
  assign wr_ctl.rb = reg_wdata[RB_BIT];
  assign wr_ctl.wb = reg_wdata[WB_BIT];

  edac_cfg_ctl u_ctl (
    .clk(clk), .rst(rst), .wr(reg_wr), .wr_ctl(wr_ctl), .ctl(ctl)
  );

  edac_cfg_tcb #(.CBW(CBW)) u_tcb (
    .clk(clk), .rst(rst), .wr(reg_wr), .wr_val(reg_wdata[TCB_HI:TCB_LO]),
    .cap_en(ctl.rb), .rd_done(rd_done), .rd_chk(rd_chk), .tcb(tst_chk)
  );

  edac_cfg_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr(reg_wr), .wr_val(reg_wdata[CNT_W-1:0]),
    .inc(err_single), .cnt(sec)
  );

  assign edac_en = ctl.en;
  assign rd_byp  = ctl.rb;
  assign wr_byp  = ctl.wb;

  always_comb begin
    reg_rdata                = '0;
    reg_rdata[CNT_W-1:0]     = sec;
    reg_rdata[TCB_HI:TCB_LO] = tst_chk;
    reg_rdata[EN_BIT]        = ctl.en;
    reg_rdata[RB_BIT]        = ctl.rb;
    reg_rdata[WB_BIT]        = ctl.wb;
  end
endmodule

// File: rtl/edac_cfg_reg_chk.sv
module edac_cfg_reg_chk #(
  parameter int DATA_W = 32,
  parameter int CBW    = 7,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              err_single,
  input logic              rd_done,
  input logic [CBW-1:0]    rd_chk,
  input logic              edac_en,
  input logic              rd_byp,
  input logic              wr_byp,
  input logic [CBW-1:0]    tst_chk
);
  localparam int TCB_LO = CNT_W;
  localparam int TCB_HI = CNT_W + CBW - 1;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sec;
  logic [CNT_W-1:0] wsec;
  logic             clr_wr;
  assign sec    = reg_rdata[CNT_W-1:0];
  assign wsec   = reg_wdata[CNT_W-1:0];
  assign clr_wr = reg_wr && (wsec == TOP);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !edac_en && !rd_byp && !wr_byp && tst_chk == '0));

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (err_single && !clr_wr && sec != TOP) |=> sec == CNT_W'($past(sec) + 1'b1));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (sec == TOP && !clr_wr) |=> sec == TOP);

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> sec == '0);

  a_r5_other_keep: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && wsec != TOP && !err_single) |=> $stable(sec));

  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (rd_byp && rd_done && !reg_wr) |=> tst_chk == $past(rd_chk));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> tst_chk == $past(reg_wdata[TCB_HI:TCB_LO]));

  a_r8_clear_beats_inc: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && err_single) |=> sec == '0);

  a_r9_ctl_load: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (edac_en == $past(reg_wdata[DATA_W-1]) &&
                rd_byp  == $past(reg_wdata[DATA_W-2]) &&
                wr_byp  == $past(reg_wdata[DATA_W-3])));

  a_r10_no_capture: assert property (@(posedge clk) disable iff (rst)
    (!rd_byp && !reg_wr) |=> $stable(tst_chk));
endmodule

bind edac_cfg_reg edac_cfg_reg_chk #(.DATA_W(DATA_W), .CBW(CBW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .err_single(err_single), .rd_done(rd_done),
  .rd_chk(rd_chk), .edac_en(edac_en), .rd_byp(rd_byp), .wr_byp(wr_byp),
  .tst_chk(tst_chk)
);

// File: tb/tb_edac_cfg_reg.sv
module tb_edac_cfg_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_single = 1'b0;
  logic        rd_done = 1'b0;
  logic [6:0]  rd_chk = '0;
  logic        edac_en, rd_byp, wr_byp;
  logic [6:0]  tst_chk;

  always #2 clk = ~clk;

  edac_cfg_reg dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_single(err_single), .rd_done(rd_done),
    .rd_chk(rd_chk), .edac_en(edac_en), .rd_byp(rd_byp), .wr_byp(wr_byp),
    .tst_chk(tst_chk)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    cmp_on = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_sec = 0, m_tcb = 0, m_en = 0, m_rb = 0, m_wb = 0;

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w        = '0;
    w[7:0]   = m_sec[7:0];
    w[14:8]  = m_tcb[6:0];
    w[31]    = m_en[0];
    w[30]    = m_rb[0];
    w[29]    = m_wb[0];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sec = 0; m_tcb = 0; m_en = 0; m_rb = 0; m_wb = 0;
    end else begin
      if (reg_wr) begin
        m_en  = reg_wdata[31];
        m_rb  = reg_wdata[30];
        m_wb  = reg_wdata[29];
        m_tcb = reg_wdata[14:8];
      end else if (m_rb == 1 && rd_done) begin
        m_tcb = rd_chk;
      end
      if (reg_wr && reg_wdata[7:0] == 8'd255) m_sec = 0;
      else if (err_single && m_sec < 255) m_sec = m_sec + 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [31:0] exp;
      exp = model_word();
      checks++;
      if (reg_rdata !== exp || edac_en !== exp[31] || rd_byp !== exp[30] ||
          wr_byp !== exp[29] || tst_chk !== exp[14:8]) begin
        fails++;
        $display("FAIL %s: word %h en %b rb %b wb %b tcb %h, expected word %h",
                 cur_req, reg_rdata, edac_en, rd_byp, wr_byp, tst_chk, exp);
      end
    end
  end

  task automatic step(input logic w, input logic [31:0] d, input logic e,
                      input logic r, input logic [6:0] c);
    @(negedge clk); #1;
    reg_wr = w; reg_wdata = d; err_single = e; rd_done = r; rd_chk = c;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic expect_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input bit en, input bit rb, input bit wb,
                                      input logic [6:0] tcb, input logic [7:0] sec);
    logic [31:0] w;
    w = '0; w[31] = en; w[30] = rb; w[29] = wb; w[14:8] = tcb; w[7:0] = sec;
    return w;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_val("R1", int'(reg_rdata), 0);
    expect_val("R1", int'(tst_chk), 0);
    #1 rst = 1'b0;
    cmp_on = 1;

    // R9: control bits load
    cur_req = "R9";
    step(1'b1, word(1, 0, 1, 7'h2a, 8'd0), 0, 0, '0);
    idle();
    expect_val("R9", {edac_en, rd_byp, wr_byp}, 3'b101);
    expect_val("R9", int'(tst_chk), 'h2a);

    // R2: increments
    cur_req = "R2";
    for (int i = 0; i < 5; i++) step(0, '0, 1, 0, '0);
    idle();
    expect_val("R2", int'(reg_rdata[7:0]), 5);

    // R3: saturation
    cur_req = "R3";
    for (int i = 0; i < 260; i++) step(0, '0, 1, 0, '0);
    idle();
    expect_val("R3", int'(reg_rdata[7:0]), 255);

    // R5: non-clearing writes keep the count
    cur_req = "R5";
    step(1'b1, word(1, 0, 1, 7'h2a, 8'd3), 0, 0, '0);
    idle();
    expect_val("R5", int'(reg_rdata[7:0]), 255);
    step(1'b1, word(1, 0, 1, 7'h2a, 8'd254), 0, 0, '0);
    idle();
    expect_val("R5", int'(reg_rdata[7:0]), 255);

    // R8: clear and increment together
    cur_req = "R8";
    step(1'b1, word(1, 0, 0, 7'h11, 8'd255), 1, 0, '0);
    idle();
    expect_val("R8", int'(reg_rdata[7:0]), 0);

    // R4: plain clear after a few errors
    cur_req = "R4";
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, '0);
    step(1'b1, word(1, 0, 0, 7'h11, 8'd255), 0, 0, '0);
    idle();
    expect_val("R4", int'(reg_rdata[7:0]), 0);

    // R10: no capture while read bypass clear
    cur_req = "R10";
    step(0, '0, 0, 1, 7'h55);
    idle();
    expect_val("R10", int'(tst_chk), 'h11);

    // R6: capture while read bypass set
    cur_req = "R6";
    step(1'b1, word(1, 1, 0, 7'h00, 8'd0), 0, 0, '0);
    step(0, '0, 0, 1, 7'h4c);
    idle();
    expect_val("R6", int'(tst_chk), 'h4c);
    step(0, '0, 0, 1, 7'h13);
    idle();
    expect_val("R6", int'(reg_rdata[14:8]), 'h13);

    // R7: software write beats capture
    cur_req = "R7";
    step(1'b1, word(1, 1, 1, 7'h7e, 8'd0), 0, 1, 7'h01);
    idle();
    expect_val("R7", int'(tst_chk), 'h7e);

    // mixed traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 8 == 0) d[7:0] = 8'd255;
      step(($urandom % 12) == 0, d, ($urandom % 2) == 0, ($urandom % 3) == 0, 7'($urandom));
    end
    idle();
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule